// File: doc/BRIEF.md
# Receive Descriptor Prefetch Controller

This block decides when a network receive path should pull more receive descriptors from a ring in host memory into its on-chip descriptor cache. It keeps two running counts: the descriptors already on chip that are valid and not yet consumed, and the descriptors waiting in host memory. The host count is the distance from an internal fetch pointer up to the tail index written by software.

A 32-bit control word sets three 6-bit thresholds and a unit flag. The first threshold is a low-water mark for the on-chip stock. The second is the minimum host stock worth fetching. The third applies to write-back; this block only stores it and drives it out. The unit flag selects whether the first two thresholds count descriptors or cache lines. A cache line of N bytes holds N/16 descriptors.

A fetch is started only when three conditions hold in the same cycle: the on-chip stock is under its threshold, the host stock is at or above its threshold, and no higher-priority DMA traffic is pending. When they hold, the block raises a single burst request toward a DMA arbiter and keeps it up until the arbiter accepts it. The block then waits for the burst to complete before it starts another one.

Top module: `rxpf_prefetch`

## Requirements
- R1: After a synchronous reset, `cfg_rdata`, `wb_thresh`, `onchip_cnt`, `fetch_idx` and `fetch_req` are all zero.
- R2: A control write stores the on-chip threshold in bits 5:0, the host threshold in bits 13:8, the write-back threshold in bits 21:16 and the unit flag in bit 24. Every other bit of `cfg_rdata` reads as zero, whatever value was written to it.
- R3: `wb_thresh` always equals the stored bits 21:16 and does not affect when fetches are made.
- R4: With the unit flag set to 1, a threshold counts descriptors. With the flag at 0, a threshold counts lines of `line_bytes`/16 descriptors each, with any `line_bytes` below 16 treated as one descriptor per line. In line units, the result in descriptors is clamped to 31.
- R5: `host_cnt` equals `tail_idx` minus `fetch_idx`, modulo 2^RING_AW.
- R6: A request is raised in the cycle after a cycle in which `onchip_cnt` is strictly below the on-chip threshold, `host_cnt` is at least the host threshold and `hipri_pend` is low, and while no fetch is outstanding.
- R7: `fetch_len` is the smallest of three values: the free cache slots (CACHE_DEPTH − `onchip_cnt`), `host_cnt`, and 31. A burst of length zero is never requested.
- R8: `fetch_req` and `fetch_len` hold steady until `fetch_ack`. After the acknowledge, no new request is raised until `fetch_done` has been seen.
- R9: When a request is acknowledged, `fetch_idx` advances by `fetch_len` (wrapping) on the next cycle.
- R10: On `fetch_done`, `onchip_cnt` rises by the burst length. Each `consume` pulse lowers it by one. When both occur in the same cycle, the net change is the burst length minus one.
- R11: A `consume` pulse while `onchip_cnt` is zero, with no completion in the same cycle, leaves the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| line_bytes | input | 8 | Static cache-line size in bytes |
| tail_idx | input | RING_AW | Ring tail index supplied by software |
| hipri_pend | input | 1 | Higher-priority DMA traffic pending |
| consume | input | 1 | One on-chip descriptor consumed this cycle |
| fetch_req | output | 1 | Burst fetch request to the arbiter |
| fetch_len | output | 5 | Burst length in descriptors |
| fetch_idx | output | RING_AW | Ring index where the next fetch begins |
| fetch_ack | input | 1 | Arbiter accepted the request |
| fetch_done | input | 1 | Outstanding burst has landed on chip |
| host_cnt | output | RING_AW | Valid descriptors waiting in host memory |
| onchip_cnt | output | $clog2(CACHE_DEPTH+1) | Valid unprocessed descriptors on chip |
| wb_thresh | output | 6 | Stored write-back threshold |

## Verification
Two on-chip count updates can fall into the same cycle: a burst completion that adds the burst length, and a consume pulse that removes one. The bench drives `fetch_done` and `consume` together and expects the net change of length minus one. It also drives a consume at a count of zero, alone, and expects no change. A behavioural model tracks both counts, the fetch pointer and the request state, and compares them with the outputs every cycle. So any skew between the two update paths shows up in the cycle where it occurs.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

    localparam int DESC_BYTES = 16;
    localparam int BURST_CAP  = 31;
    localparam int THR_CAP    = 31;
    localparam int THR_W      = 6;
    localparam int LEN_W      = 5;

    typedef struct packed {
        logic             unit_desc;
        logic [THR_W-1:0] wb_thr;
        logic [THR_W-1:0] host_thr;
        logic [THR_W-1:0] low_thr;
    } rxpf_cfg_t;

    typedef enum logic [1:0] {
        PF_IDLE = 2'd0,
        PF_REQ  = 2'd1,
        PF_WAIT = 2'd2
    } pf_state_e;

    function automatic rxpf_cfg_t word_to_cfg(input logic [31:0] w);
        rxpf_cfg_t c;
        c.low_thr   = w[5:0];
        c.host_thr  = w[13:8];
        c.wb_thr    = w[21:16];
        c.unit_desc = w[24];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input rxpf_cfg_t c);
        logic [31:0] w;
        w        = '0;
        w[5:0]   = c.low_thr;
        w[13:8]  = c.host_thr;
        w[21:16] = c.wb_thr;
        w[24]    = c.unit_desc;
        return w;
    endfunction

    function automatic logic [3:0] desc_per_line(input logic [7:0] lb);
        return (lb < 8'(DESC_BYTES)) ? 4'd1 : lb[7:4];
    endfunction

    function automatic logic [THR_W-1:0] thr_in_desc(input logic [THR_W-1:0] f,
                                                     input logic unit_desc,
                                                     input logic [3:0] dpl);
        logic [9:0] prod;
        prod = {4'b0, f} * {6'b0, dpl};
        if (unit_desc)
            return f;
        return (prod > 10'(THR_CAP)) ? THR_W'(THR_CAP) : prod[THR_W-1:0];
    endfunction

endpackage

// File: rtl/rxpf_cfg_reg.sv
module rxpf_cfg_reg
    import rxpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output rxpf_cfg_t   cfg,
    output logic [31:0] rdata
);
    rxpf_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (we)
            cfg_q <= word_to_cfg(wdata);
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_to_word(cfg_q);
endmodule

// File: rtl/rxpf_thr_conv.sv
module rxpf_thr_conv
    import rxpf_pkg::*;
(
    input  logic [THR_W-1:0] field,
    input  logic             unit_desc,
    input  logic [7:0]       line_bytes,
    output logic [THR_W-1:0] thr_desc
);
    logic [3:0] dpl;

    assign dpl      = desc_per_line(line_bytes);
    assign thr_desc = thr_in_desc(field, unit_desc, dpl);
endmodule

// File: rtl/rxpf_ring_track.sv
module rxpf_ring_track
    import rxpf_pkg::*;
#(
    parameter int RING_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RING_AW-1:0] tail,
    input  logic               adv,
    input  logic [LEN_W-1:0]   adv_len,
    output logic [RING_AW-1:0] fptr,
    output logic [RING_AW-1:0] host_cnt
);
    logic [RING_AW-1:0] fptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            fptr_q <= '0;
        else if (adv)
            fptr_q <= fptr_q + RING_AW'(adv_len);
    end

    assign fptr     = fptr_q;
    assign host_cnt = tail - fptr_q;
endmodule

// File: rtl/rxpf_stock.sv
module rxpf_stock
    import rxpf_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [LEN_W-1:0] add_len,
    input  logic             consume,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q} + (CNT_W+1)'(add_en ? add_len : '0);
        if (consume && (sum != '0))
            sum = sum - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= sum[CNT_W-1:0];
    end

    assign count = cnt_q;
endmodule

// File: rtl/rxpf_fetch_ctrl.sv
module rxpf_fetch_ctrl
    import rxpf_pkg::*;
#(
    parameter int RING_AW     = 8,
    parameter int CACHE_DEPTH = 64,
    parameter int CNT_W       = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   onchip,
    input  logic [RING_AW-1:0] host,
    input  logic [THR_W-1:0]   low_thr_d,
    input  logic [THR_W-1:0]   host_thr_d,
    input  logic               hipri,
    input  logic               ack,
    input  logic               done,
    output logic               req,
    output logic [LEN_W-1:0]   len,
    output logic               adv,
    output logic               add_en
);
    pf_state_e        st_q;
    logic [LEN_W-1:0] len_q;
    int               free_i;
    int               cand_i;
    logic             go;

    always_comb begin
        free_i = CACHE_DEPTH - int'(onchip);
        cand_i = BURST_CAP;
        if (free_i < cand_i)
            cand_i = free_i;
        if (int'(host) < cand_i)
            cand_i = int'(host);
        go = (st_q == PF_IDLE) && !hipri && (cand_i > 0) &&
             (int'(onchip) < int'(low_thr_d)) &&
             (int'(host) >= int'(host_thr_d));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PF_IDLE;
            len_q <= '0;
        end else begin
            unique case (st_q)
                PF_IDLE: if (go) begin
                    st_q  <= PF_REQ;
                    len_q <= LEN_W'(cand_i);
                end
                PF_REQ:  if (ack)  st_q <= PF_WAIT;
                PF_WAIT: if (done) st_q <= PF_IDLE;
                default: st_q <= PF_IDLE;
            endcase
        end
    end

    assign req    = (st_q == PF_REQ);
    assign len    = len_q;
    assign adv    = (st_q == PF_REQ) && ack;
    assign add_en = (st_q == PF_WAIT) && done;
endmodule

// File: rtl/rxpf_prefetch.sv
module rxpf_prefetch
    import rxpf_pkg::*;
#(
    parameter int RING_AW     = 8,
    parameter int CACHE_DEPTH = 64
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [31:0]                        cfg_wdata,
    output logic [31:0]                        cfg_rdata,
    input  logic [7:0]                         line_bytes,
    input  logic [RING_AW-1:0]                 tail_idx,
    input  logic                               hipri_pend,
    input  logic                               consume,
    output logic                               fetch_req,
    output logic [4:0]                         fetch_len,
    output logic [RING_AW-1:0]                 fetch_idx,
    input  logic                               fetch_ack,
    input  logic                               fetch_done,
    output logic [RING_AW-1:0]                 host_cnt,
    output logic [$clog2(CACHE_DEPTH+1)-1:0]   onchip_cnt,
    output logic [5:0]                         wb_thresh
);
    localparam int CNT_W = $clog2(CACHE_DEPTH + 1);
    localparam int N_THR = 2;

    rxpf_cfg_t        cfg;
    logic [THR_W-1:0] thr_field [N_THR];
    logic [THR_W-1:0] thr_desc  [N_THR];
    logic             adv;
    logic             add_en;

    rxpf_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    assign thr_field[0] = cfg.low_thr;
    assign thr_field[1] = cfg.host_thr;

    for (genvar g = 0; g < N_THR; g++) begin : g_conv
        rxpf_thr_conv u_conv (
            .field      (thr_field[g]),
            .unit_desc  (cfg.unit_desc),
            .line_bytes (line_bytes),
            .thr_desc   (thr_desc[g])
        );
    end

    rxpf_ring_track #(.RING_AW(RING_AW)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .tail     (tail_idx),
        .adv      (adv),
        .adv_len  (fetch_len),
        .fptr     (fetch_idx),
        .host_cnt (host_cnt)
    );

    rxpf_stock #(.CNT_W(CNT_W)) u_stock (
        .clk     (clk),
        .rst     (rst),
        .add_en  (add_en),
        .add_len (fetch_len),
        .consume (consume),
        .count   (onchip_cnt)
    );

    rxpf_fetch_ctrl #(
        .RING_AW     (RING_AW),
        .CACHE_DEPTH (CACHE_DEPTH),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .onchip     (onchip_cnt),
        .host       (host_cnt),
        .low_thr_d  (thr_desc[0]),
        .host_thr_d (thr_desc[1]),
        .hipri      (hipri_pend),
        .ack        (fetch_ack),
        .done       (fetch_done),
        .req        (fetch_req),
        .len        (fetch_len),
        .adv        (adv),
        .add_en     (add_en)
    );

    assign wb_thresh = cfg.wb_thr;
endmodule

// File: rtl/rxpf_checker.sv
module rxpf_checker #(
    parameter int RING_AW     = 8,
    parameter int CACHE_DEPTH = 64
) (
    input logic                             clk,
    input logic                             rst,
    input logic [31:0]                      cfg_rdata,
    input logic                             hipri_pend,
    input logic                             consume,
    input logic                             fetch_req,
    input logic [4:0]                       fetch_len,
    input logic [RING_AW-1:0]               fetch_idx,
    input logic                             fetch_ack,
    input logic                             fetch_done,
    input logic [$clog2(CACHE_DEPTH+1)-1:0] onchip_cnt
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & 32'hFEC0_C0C0) == 32'h0);                                   // R2

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_req) |-> !$past(hipri_pend));                                // R6

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (fetch_len != 5'd0));                                      // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_len)));        // R8

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_ack) |=> !fetch_req);                                // R8

    AST_ACK_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_ack) |=>
        (fetch_idx == RING_AW'($past(fetch_idx) + RING_AW'($past(fetch_len))))); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(onchip_cnt) <= CACHE_DEPTH);                                        // R10

    AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (onchip_cnt == '0 && consume && !fetch_done) |=> (onchip_cnt == '0));    // R11
endmodule

bind rxpf_prefetch rxpf_checker #(
    .RING_AW     (RING_AW),
    .CACHE_DEPTH (CACHE_DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_rdata  (cfg_rdata),
    .hipri_pend (hipri_pend),
    .consume    (consume),
    .fetch_req  (fetch_req),
    .fetch_len  (fetch_len),
    .fetch_idx  (fetch_idx),
    .fetch_ack  (fetch_ack),
    .fetch_done (fetch_done),
    .onchip_cnt (onchip_cnt)
);

// File: tb/rxpf_prefetch_test.sv
`timescale 1ns/1ps
module rxpf_prefetch_test;
    localparam int AW    = 8;
    localparam int RING  = 256;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [7:0]    line_bytes = 8'd64;
    logic [AW-1:0] tail_idx = '0;
    logic          hipri_pend = 1'b0;
    logic          consume = 1'b0;
    logic          fetch_req;
    logic [4:0]    fetch_len;
    logic [AW-1:0] fetch_idx;
    logic          fetch_ack = 1'b0;
    logic          fetch_done = 1'b0;
    logic [AW-1:0] host_cnt;
    logic [CW-1:0] onchip_cnt;
    logic [5:0]    wb_thresh;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rxpf_prefetch #(.RING_AW(AW), .CACHE_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .line_bytes(line_bytes), .tail_idx(tail_idx),
        .hipri_pend(hipri_pend), .consume(consume), .fetch_req(fetch_req),
        .fetch_len(fetch_len), .fetch_idx(fetch_idx), .fetch_ack(fetch_ack),
        .fetch_done(fetch_done), .host_cnt(host_cnt), .onchip_cnt(onchip_cnt),
        .wb_thresh(wb_thresh)
    );

    // ---------------- behavioural reference model ----------------
    int m_low, m_host_thr, m_wb, m_unit;
    int m_fptr, m_on, m_st, m_len;

    function automatic int to_desc(input int f);
        int per_line;
        int v;
        per_line = (line_bytes < 16) ? 1 : int'(line_bytes) / 16;
        if (m_unit != 0) return f;
        v = f * per_line;
        return (v > 31) ? 31 : v;
    endfunction

    function automatic int m_hostcnt();
        return ((int'(tail_idx) - m_fptr) % RING + RING) % RING;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_low = 0; m_host_thr = 0; m_wb = 0; m_unit = 0;
            m_fptr = 0; m_on = 0; m_st = 0; m_len = 0;
        end else begin
            int h, b, add, nxt;
            h   = m_hostcnt();
            add = 0;
            if (m_st == 0) begin
                b = DEPTH - m_on;
                if (h < b) b = h;
                if (b > 31) b = 31;
                if (m_on < to_desc(m_low) && h >= to_desc(m_host_thr) &&
                    !hipri_pend && b > 0) begin
                    m_st = 1; m_len = b;
                end
            end else if (m_st == 1) begin
                if (fetch_ack) begin
                    m_fptr = (m_fptr + m_len) % RING; m_st = 2;
                end
            end else if (fetch_done) begin
                add = m_len; m_st = 0;
            end
            nxt = m_on + add;
            if (consume && nxt > 0) nxt = nxt - 1;
            m_on = nxt;
            if (cfg_we) begin
                m_low      = int'(cfg_wdata[5:0]);
                m_host_thr = int'(cfg_wdata[13:8]);
                m_wb       = int'(cfg_wdata[21:16]);
                m_unit     = int'(cfg_wdata[24]);
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            int rd;
            rd = m_low | (m_host_thr << 8) | (m_wb << 16) | (m_unit << 24);
            chk("R2 model cfg_rdata", int'(cfg_rdata), rd);
            chk("R3 model wb_thresh", int'(wb_thresh), m_wb);
            chk("R5 model host_cnt", int'(host_cnt), m_hostcnt());
            chk("R6 model fetch_req", int'(fetch_req), (m_st == 1) ? 1 : 0);
            if (m_st == 1) chk("R7 model fetch_len", int'(fetch_len), m_len);
            chk("R9 model fetch_idx", int'(fetch_idx), m_fptr);
            chk("R10 model onchip_cnt", int'(onchip_cnt), m_on);
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    // ---------------- stimulus helpers (drive at negedge only) ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (fetch_req) break;
        end
    endtask

    task automatic ack_now();
        fetch_ack = 1'b1;
        @(negedge clk); fetch_ack = 1'b0;
    endtask

    task automatic done_now();
        @(negedge clk); fetch_done = 1'b1;
        @(negedge clk); fetch_done = 1'b0;
    endtask

    task automatic serve(input int exp_len, input string tag);
        wait_req();
        #1 chk(tag, int'(fetch_len), exp_len);
        @(negedge clk);   // keep request one more cycle (R8 hold)
        ack_now();
        done_now();
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        #1;
        chk("R1 reset cfg_rdata", int'(cfg_rdata), 0);
        chk("R1 reset fetch_req", int'(fetch_req), 0);
        chk("R1 reset onchip_cnt", int'(onchip_cnt), 0);
        chk("R1 reset fetch_idx", int'(fetch_idx), 0);

        // R2/R3: field placement and reserved bits
        write_cfg(32'hFFFF_FFFF);
        #1 chk("R2 all-ones read-back", int'(cfg_rdata), 32'h013F3F3F);
        chk("R3 wb_thresh", int'(wb_thresh), 63);
        write_cfg(32'h00C0_C0C0);
        #1 chk("R2 reserved-only write", int'(cfg_rdata), 0);

        // R6/R7: low=8 host=4 descriptor units
        write_cfg(32'h0100_0408);
        tail_idx = 8'd3;
        step(4);
        #1 chk("R6 host below threshold no req", int'(fetch_req), 0);
        @(negedge clk); tail_idx = 8'd10;
        wait_req();
        #1 chk("R7 len host-limited", int'(fetch_len), 10);
        @(negedge clk);
        ack_now();
        #1 chk("R9 idx after ack", int'(fetch_idx), 10);
        chk("R5 host after ack", int'(host_cnt), 0);
        @(negedge clk); tail_idx = 8'd40;
        step(3);
        #1 chk("R8 no req while outstanding", int'(fetch_req), 0);
        done_now();
        #1 chk("R10 onchip after done", int'(onchip_cnt), 10);

        // R6: hipri blocks
        @(negedge clk); hipri_pend = 1'b1; consume = 1'b1;
        step(3); consume = 1'b0;
        step(4);
        #1 chk("R6 hipri holds off", int'(fetch_req), 0);
        chk("R10 onchip after consumes", int'(onchip_cnt), 7);
        @(negedge clk); hipri_pend = 1'b0;
        wait_req();
        #1 chk("R7 len 30", int'(fetch_len), 30);
        @(negedge clk);
        ack_now();
        step(1);
        fetch_done = 1'b1; consume = 1'b1;
        @(negedge clk); fetch_done = 1'b0; consume = 1'b0;
        #1 chk("R10 done+consume same cycle", int'(onchip_cnt), 36);

        // R11: consume at zero
        write_cfg(32'h0100_0400);
        @(negedge clk); consume = 1'b1;
        step(40); consume = 1'b0;
        #1 chk("R11 floor at zero", int'(onchip_cnt), 0);

        // R4: line units, 64-byte lines -> low 2*4=8, host 20*4 clamped 31
        line_bytes = 8'd64;
        write_cfg(32'h0000_1402);
        tail_idx = 8'd60;
        step(4);
        #1 chk("R4 clamped host threshold blocks 20", int'(fetch_req), 0);
        @(negedge clk); tail_idx = 8'd71;
        serve(31, "R4 clamp reached len");
        #1 chk("R10 onchip 31", int'(onchip_cnt), 31);

        // R4: tiny line treated as one desc per line, low 40 -> 31
        line_bytes = 8'd0;
        write_cfg(32'h0000_1428);
        tail_idx = 8'd171;
        step(4);
        #1 chk("R4 onchip equal threshold no req", int'(fetch_req), 0);
        @(negedge clk); consume = 1'b1;
        @(negedge clk); consume = 1'b0;
        serve(31, "R4 strictly below threshold fetch");

        // R7: free-slot limited burst
        write_cfg(32'h0100_143F);
        serve(3, "R7 len free-slot limited");
        #1 chk("R10 cache full", int'(onchip_cnt), 64);

        // R5: ring wrap
        write_cfg(32'h0100_0400);
        @(negedge clk); consume = 1'b1;
        step(66); consume = 1'b0;
        tail_idx = 8'd49;
        #1 chk("R5 wrapped host count", int'(host_cnt), 200);
        write_cfg(32'h0100_0101);
        wait_req();
        #1 chk("R7 len capped 31", int'(fetch_len), 31);
        @(negedge clk);
        ack_now();
        #1 chk("R9 idx 136", int'(fetch_idx), 136);
        chk("R5 host after wrap ack", int'(host_cnt), 169);
        done_now();
        step(4);
        finish_run();
    end
endmodule